// File: doc/BRIEF.md
# GPIO Output Latch and Pin Function Bank

This block keeps the output state, the drive direction and the function choice for one bank of general-purpose pins. Software reaches it through a small word-addressed register port with a one-cycle write strobe and a combinational read. The output latch is never rewritten whole. A write to the set word raises the latches under its one bits. A write to the clear word lowers the latches under its one bits. Because of this, two agents can change different pins without a read-modify-write sequence.

Each pin also has a 2-bit function field. Field value 0 leaves the pin under plain GPIO control. Values 1, 2 and 3 hand the pin's output value to one of three peripheral drive vectors. They also steer the pin's sensed level to the matching peripheral sense vector. The direction bit always decides whether the pad drives. Software can therefore load the latch first and then turn on the driver, so the pin starts out at the intended level.

Word map (3-bit address): 0 pin level (read only), 1 direction, 2 set strobe, 3 clear strobe, 4 function word for pins 0–15, 5 function word for pins 16–31. Addresses 6 and 7 are unused.

Top module: `gpio_bank`

## Requirements
- R1: After reset, direction bits, output latches and function fields are all zero: `pin_oe` and `pin_out` are all zero, and reads of the direction word and both function words return zero.
- R2: A write to address 2 sets the output latch of every pin whose data bit is 1 and leaves the latches under 0 bits unchanged. With function 0, the latch is visible on `pin_out` regardless of direction.
- R3: A write to address 3 clears the output latch of every pin whose data bit is 1 and leaves the latches under 0 bits unchanged.
- R4: Address 1 is the read/write direction word. A bit of 1 makes the pin drive (`pin_oe` = 1), and a bit of 0 makes it an input.
- R5: A read of address 0 returns `pin_in` as it is, whatever the direction bits are. A write to address 0 changes nothing.
- R6: The function field of pin n is bits [2*(n mod 16)+1 : 2*(n mod 16)] of the function word at address 4 + n/16. These words read back what was written.
- R7: With function f ≠ 0, `pin_out[n]` equals `fnf_drive[n]` rather than the latch, and `pin_oe[n]` still follows the direction bit.
- R8: While a pin is in a peripheral function, its latch keeps its value and still accepts set and clear writes. Returning the field to 0 shows the latch on `pin_out` again.
- R9: Addresses 2 and 3 read as zero.
- R10: `fnf_sense[n]` equals `pin_in[n]` when pin n's field is f, and is 0 otherwise.
- R11: A register write changes `pin_out` and `pin_oe` after the clock edge that samples the strobe, and not before.
- R12: Addresses 6 and 7 read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | NUM_PINS | Sensed pin levels |
| pin_out | output | NUM_PINS | Output value to the pads |
| pin_oe | output | NUM_PINS | Output enable to the pads |
| fn1_drive | input | NUM_PINS | Peripheral drive vector for function 1 |
| fn2_drive | input | NUM_PINS | Peripheral drive vector for function 2 |
| fn3_drive | input | NUM_PINS | Peripheral drive vector for function 3 |
| fn1_sense | output | NUM_PINS | Pin levels routed to function 1 |
| fn2_sense | output | NUM_PINS | Pin levels routed to function 2 |
| fn3_sense | output | NUM_PINS | Pin levels routed to function 3 |

## Verification
The bench builds the bank with NUM_PINS = 32, which fills the data word and uses both function words. At this width, pin 30 lands in the upper half of the second word, which exercises the n/16 and n mod 16 field placement. The same width lets a single vector hold bits for every pin at once, so the tests can set, clear and mix all three functions together with plain GPIO pins in one pattern.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W        = 3;
  localparam int DATA_W        = 32;
  localparam int FSEL_W        = 2;
  localparam int FSEL_PER_WORD = DATA_W / FSEL_W;

  localparam logic [ADDR_W-1:0] A_LEVEL     = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR       = 3'd1;
  localparam logic [ADDR_W-1:0] A_SET       = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR       = 3'd3;
  localparam logic [ADDR_W-1:0] A_FSEL_BASE = 3'd4;

  typedef logic [FSEL_W-1:0] fsel_t;
  localparam fsel_t FSEL_GPIO = 2'd0;
  localparam fsel_t FSEL_FN1  = 2'd1;
  localparam fsel_t FSEL_FN2  = 2'd2;
  localparam fsel_t FSEL_FN3  = 2'd3;
endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic                dir_en,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] dir_q
);
  logic [NUM_PINS-1:0] latch_d;
  logic [NUM_PINS-1:0] dir_d;
  logic                latch_ce;

  assign latch_ce = set_en | clr_en;

  // Clear is applied after set, so it dominates if both are ever active.
  always_comb begin
    latch_d = latch_q;
    if (set_en) latch_d = latch_d | wdata;
    if (clr_en) latch_d = latch_d & ~wdata;
    dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (latch_ce) latch_q <= latch_d;
      if (dir_en)   dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          rd_idx,
  output logic [NUM_PINS*FSEL_W-1:0] fsel_flat,
  output logic [DATA_W-1:0]          rd_word
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD  = p / FSEL_PER_WORD;
    localparam int SHIFT = (p % FSEL_PER_WORD) * FSEL_W;
    logic  hit;
    fsel_t fsel_d;
    fsel_t fsel_q;

    assign hit = wr_en && (wr_idx == ADDR_W'(WORD));

    always_comb fsel_d = wdata[SHIFT +: FSEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fsel_q <= FSEL_GPIO;
      else if (hit) fsel_q <= fsel_d;
    end

    assign fsel_flat[p*FSEL_W +: FSEL_W] = fsel_q;
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx == ADDR_W'(p / FSEL_PER_WORD))
        rd_word[(p % FSEL_PER_WORD)*FSEL_W +: FSEL_W] = fsel_flat[p*FSEL_W +: FSEL_W];
    end
  end
endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]        latch_q,
  input  logic [NUM_PINS-1:0]        dir_q,
  input  logic [NUM_PINS*FSEL_W-1:0] fsel_flat,
  input  logic [NUM_PINS-1:0]        pin_in,
  input  logic [NUM_PINS-1:0]        fn1_drive,
  input  logic [NUM_PINS-1:0]        fn2_drive,
  input  logic [NUM_PINS-1:0]        fn3_drive,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS-1:0]        fn1_sense,
  output logic [NUM_PINS-1:0]        fn2_sense,
  output logic [NUM_PINS-1:0]        fn3_sense
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
    fsel_t sel;
    assign sel = fsel_flat[p*FSEL_W +: FSEL_W];

    always_comb begin
      unique case (sel)
        FSEL_FN1: pin_out[p] = fn1_drive[p];
        FSEL_FN2: pin_out[p] = fn2_drive[p];
        FSEL_FN3: pin_out[p] = fn3_drive[p];
        default:  pin_out[p] = latch_q[p];
      endcase
    end

    assign pin_oe[p]    = dir_q[p];
    assign fn1_sense[p] = (sel == FSEL_FN1) & pin_in[p];
    assign fn2_sense[p] = (sel == FSEL_FN2) & pin_in[p];
    assign fn3_sense[p] = (sel == FSEL_FN3) & pin_in[p];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_PINS-1:0] fn1_drive,
  input  logic [NUM_PINS-1:0] fn2_drive,
  input  logic [NUM_PINS-1:0] fn3_drive,
  output logic [NUM_PINS-1:0] fn1_sense,
  output logic [NUM_PINS-1:0] fn2_sense,
  output logic [NUM_PINS-1:0] fn3_sense
);
  logic [1:0]                 rst_pipe;
  logic                       rst_sync_n;
  logic                       set_en;
  logic                       clr_en;
  logic                       dir_en;
  logic                       fsel_en;
  logic                       in_fsel_space;
  logic [ADDR_W-1:0]          fsel_idx;
  logic [NUM_PINS-1:0]        latch_q;
  logic [NUM_PINS-1:0]        dir_q;
  logic [NUM_PINS*FSEL_W-1:0] fsel_flat;
  logic [DATA_W-1:0]          fsel_word;

  // Asynchronous assertion, two-stage synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign in_fsel_space = (reg_addr >= A_FSEL_BASE);
  assign fsel_idx      = reg_addr - A_FSEL_BASE;
  assign set_en        = reg_we && (reg_addr == A_SET);
  assign clr_en        = reg_we && (reg_addr == A_CLR);
  assign dir_en        = reg_we && (reg_addr == A_DIR);
  assign fsel_en       = reg_we && in_fsel_space;

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (set_en),
    .clr_en  (clr_en),
    .dir_en  (dir_en),
    .wdata   (reg_wdata[NUM_PINS-1:0]),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS)) u_fsel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (fsel_en),
    .wr_idx    (fsel_idx),
    .wdata     (reg_wdata),
    .rd_idx    (fsel_idx),
    .fsel_flat (fsel_flat),
    .rd_word   (fsel_word)
  );

  gpio_pin_route #(.NUM_PINS(NUM_PINS)) u_route (
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .fsel_flat (fsel_flat),
    .pin_in    (pin_in),
    .fn1_drive (fn1_drive),
    .fn2_drive (fn2_drive),
    .fn3_drive (fn3_drive),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .fn1_sense (fn1_sense),
    .fn2_sense (fn2_sense),
    .fn3_sense (fn3_sense)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_LEVEL)     reg_rdata[NUM_PINS-1:0] = pin_in;
    else if (reg_addr == A_DIR)  reg_rdata[NUM_PINS-1:0] = dir_q;
    else if (in_fsel_space)      reg_rdata = fsel_word;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] latch_q,
  input logic [NUM_PINS-1:0] fn1_sense,
  input logic [NUM_PINS-1:0] fn2_sense,
  input logic [NUM_PINS-1:0] fn3_sense
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && latch_q == '0));

  p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET) |=>
      ((latch_q & $past(reg_wdata[NUM_PINS-1:0])) == $past(reg_wdata[NUM_PINS-1:0])));

  p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR) |=> ((latch_q & $past(reg_wdata[NUM_PINS-1:0])) == '0));

  p_oe_from_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> (pin_oe == $past(reg_wdata[NUM_PINS-1:0])));

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == A_SET || reg_addr == A_CLR)) |=> $stable(latch_q));

  p_strobe_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SET || reg_addr == A_CLR) |-> (reg_rdata == '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sense
    p_sense_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fn1_sense[p], fn2_sense[p], fn3_sense[p]}));
  end
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_oe    (pin_oe),
  .latch_q   (latch_q),
  .fn1_sense (fn1_sense),
  .fn2_sense (fn2_sense),
  .fn3_sense (fn3_sense)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int N = 32;

  logic         clk;
  logic         rst_n;
  logic         reg_we;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [N-1:0] pin_in, pin_out, pin_oe;
  logic [N-1:0] fn1_drive, fn2_drive, fn3_drive;
  logic [N-1:0] fn1_sense, fn2_sense, fn3_sense;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  gpio_bank #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fn1_drive(fn1_drive),
    .fn2_drive(fn2_drive), .fn3_drive(fn3_drive), .fn1_sense(fn1_sense),
    .fn2_sense(fn2_sense), .fn3_sense(fn3_sense)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, wdata, expected pin_out, expected pin_oe}; function fields stay 0.
  localparam logic [98:0] VEC [0:8] = '{
    {3'd2, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},
    {3'd2, 32'h0F00_0000, 32'h0F00_00FF, 32'h0000_0000},
    {3'd3, 32'h0000_000F, 32'h0F00_00F0, 32'h0000_0000},
    {3'd1, 32'hFFFF_0000, 32'h0F00_00F0, 32'hFFFF_0000},
    {3'd2, 32'h0000_0000, 32'h0F00_00F0, 32'hFFFF_0000},
    {3'd3, 32'h0F00_0000, 32'h0000_00F0, 32'hFFFF_0000},
    {3'd0, 32'hFFFF_FFFF, 32'h0000_00F0, 32'hFFFF_0000},
    {3'd7, 32'hFFFF_FFFF, 32'h0000_00F0, 32'hFFFF_0000},
    {3'd1, 32'h0000_FFFF, 32'h0000_00F0, 32'h0000_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd2: return "R2 set";
      3'd3: return "R3 clear";
      3'd1: return "R4 direction";
      3'd0: return "R5 level write ignored";
      default: return "R12 unused write ignored";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = '0; fn1_drive = '0; fn2_drive = '0; fn3_drive = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe after reset", pin_oe, '0);
    chk("R1 pin_out after reset", pin_out, '0);
    rd(3'd1, r); chk("R1 direction word", r, '0);
    rd(3'd4, r); chk("R1 function word 0", r, '0);
    rd(3'd5, r); chk("R1 function word 1", r, '0);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][98:96], VEC[i][95:64]);
      chk({tag_for(VEC[i][98:96]), " pin_out"}, pin_out, VEC[i][63:32]);
      chk({tag_for(VEC[i][98:96]), " pin_oe"},  pin_oe,  VEC[i][31:0]);
    end

    rd(3'd1, r); chk("R4 direction readback", r, 32'h0000_FFFF);

    // R5 level read independent of direction
    pin_in = 32'hA5A5_5A5A;
    rd(3'd0, r); chk("R5 level read", r, 32'hA5A5_5A5A);

    // R9 strobe words read zero
    rd(3'd2, r); chk("R9 set word reads zero", r, '0);
    rd(3'd3, r); chk("R9 clear word reads zero", r, '0);

    // Function selection
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_000F);
    wr(3'd4, 32'h0000_00E4);     // pin0=0 pin1=1 pin2=2 pin3=3
    wr(3'd5, 32'h3000_0000);     // pin30=3
    rd(3'd4, r); chk("R6 function word 0 readback", r, 32'h0000_00E4);
    rd(3'd5, r); chk("R6 function word 1 readback", r, 32'h3000_0000);

    fn1_drive = '1; fn2_drive = '0; fn3_drive = '1;
    #1 chk("R7 peripheral drive on pin_out", pin_out, 32'h4000_000A);
    chk("R7 pin_oe still from direction", pin_oe, 32'h0000_000F);

    pin_in = '1;
    #1 chk("R10 fn1_sense", fn1_sense, 32'h0000_0002);
    chk("R10 fn2_sense", fn2_sense, 32'h0000_0004);
    chk("R10 fn3_sense", fn3_sense, 32'h4000_0008);

    // R12 unused reads and writes
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, r); chk("R12 address 6 reads zero", r, '0);
    rd(3'd7, r); chk("R12 address 7 reads zero", r, '0);
    rd(3'd4, r); chk("R12 function word 0 untouched", r, 32'h0000_00E4);
    rd(3'd1, r); chk("R12 direction untouched", r, 32'h0000_000F);

    // R8 latch kept behind peripheral function
    wr(3'd2, 32'hFFFF_FFFF);
    fn1_drive = '0; fn3_drive = '0;
    #1 chk("R8 peripheral pins masked from latch", pin_out, 32'hBFFF_FFF1);
    wr(3'd4, 32'h0000_0000);
    wr(3'd5, 32'h0000_0000);
    chk("R8 latch reappears at function 0", pin_out, 32'hFFFF_FFFF);

    // R11 update timing
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0000_0001;
    #1 chk("R11 pin_out before edge", pin_out, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk("R11 pin_out after edge", pin_out, 32'hFFFF_FFFE);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;

    // R1 reset again mid-run
    wr(3'd1, 32'h1234_5678);
    wr(3'd4, 32'h5555_5555);
    do_reset();
    chk("R1 pin_oe after second reset", pin_oe, '0);
    chk("R1 pin_out after second reset", pin_out, '0);
    rd(3'd4, r); chk("R1 function word after second reset", r, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule